// File: doc/BRIEF.md
# Audio Serial-Link Clock Generator

This block takes one fast system clock and produces the three clocks an audio converter needs on a serial link. The master clock comes from a programmable integer divider. The bit clock and the left/right frame clock are fixed fractions of the master clock. The master clock is always 512 times the frame rate. The bit clock runs at either 32 or 64 times the frame rate, and the 64 times setting serves samples wider than 16 bits. The divider keeps an exact 50% duty cycle at odd ratios by using both edges of the fast clock.

Software or a pin sets the divider and may change it while the block runs. A new divide value waits for the end of the current master-clock period, so no shortened pulse reaches the converter. For example, a 20.97152 MHz fast clock divided by 5 gives a 4.194304 MHz master clock and a frame rate of 8192 Hz. At that frame rate the 32 times setting gives a 262.144 kHz bit clock. A one-cycle strobe in the fast domain marks each frame start, where the frame clock falls.

Top module: `acg_clkgen`

## Requirements
- R1: With divide value N on `div_val`, the master clock period is N fast-clock cycles; a value of 0 behaves as 1, and a value of 1 passes the fast clock through.
- R2: The master clock is high for exactly N half-cycles of the fast clock and low for N half-cycles, for odd and even N alike.
- R3: A divide value of 5 gives a master clock period of 5 fast cycles with 2.5 cycles high (4.194304 MHz from 20.97152 MHz).
- R4: A change of `div_val` takes effect only at a master clock period boundary; every observed period is entirely of the old or entirely of the new value.
- R5: With `bclk_sel` = 0 the bit clock period is 16 master clock periods (32 × fs); with `bclk_sel` = 1 it is 8 master clock periods (64 × fs); the duty cycle is 50%.
- R6: The frame clock period is 512 master clock periods; it is low for the first 256 and high for the last 256.
- R7: The bit clock and the frame clock change only on the rising fast-clock edge that ends the master clock high count; for even N this is the master clock falling edge.
- R8: Every frame clock transition coincides with a falling edge of the bit clock.
- R9: `frame_stb` is high for exactly one fast cycle per frame, in the cycle in which the frame clock has just fallen; frames are 512 × N fast cycles apart.
- R10: A change of `bclk_sel` takes effect at the next frame start; the frame in progress keeps its bit clock rate.
- R11: While `rst` is high, from the first rising edge on, `mclk`, `bclk`, `lrclk` and `frame_stb` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| div_val | input | 8 | Master clock divide value (0 acts as 1) |
| bclk_sel | input | 1 | Bit clock ratio select: 0 = 32 × fs, 1 = 64 × fs |
| mclk | output | 1 | Master clock, fast clock / N, 50% duty |
| bclk | output | 1 | Bit clock |
| lrclk | output | 1 | Frame (left/right) clock, low for the first word |
| frame_stb | output | 1 | One-cycle pulse at each frame start |

## Verification
A wrong divider count or a bad half-period compare shows in the first master clock period after a change, as a high or low time that differs from N half-cycles. A frame counter that skips or stalls shifts the bit clock within 8 or 16 master periods, and shifts the frame clock and strobe spacing within one frame. A late ratio or divide update shows up as one mixed period or a mis-sized bit clock half-period in the first frame after the change. The checks therefore measure edge-to-edge spans at half-cycle resolution. They do this across a sweep of divide values, both ratios, and changes made mid-period and mid-frame.

// File: rtl/acg_pkg.sv
package acg_pkg;

    parameter int ACG_DIV_W = 8;

    typedef logic [ACG_DIV_W-1:0] div_t;

    typedef enum logic {
        BR_LOW  = 1'b0,
        BR_HIGH = 1'b1
    } bratio_e;

    typedef struct packed {
        logic bclk;
        logic lrclk;
        logic stb;
    } frame_out_t;

    // a divide value of zero is handled as one
    function automatic div_t eff_div(input div_t d);
        return (d == '0) ? div_t'(1) : d;
    endfunction

    // count of full fast cycles in the registered high phase
    function automatic div_t half_div(input div_t n);
        return n >> 1;
    endfunction

endpackage

// File: rtl/acg_mclk_div.sv
module acg_mclk_div
    import acg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  div_t div_in,
    output logic mclk,
    output logic fall_tick
);

    logic run;
    div_t cnt;
    div_t cur_n;
    div_t n_in;
    div_t n_nx;
    div_t cnt_nx;
    logic wrap;
    logic p_nx;
    logic out_p;
    logic out_n;
    logic byp;
    logic odd;

    always_comb begin
        n_in      = eff_div(div_in);
        wrap      = !run || (cnt == cur_n - div_t'(1));
        n_nx      = wrap ? n_in : cur_n;
        cnt_nx    = wrap ? '0 : cnt + div_t'(1);
        p_nx      = cnt_nx < half_div(n_nx);
        fall_tick = (out_p && !p_nx) || (n_nx == div_t'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run   <= 1'b0;
            cnt   <= '0;
            cur_n <= div_t'(1);
            out_p <= 1'b0;
        end else begin
            run   <= 1'b1;
            cnt   <= cnt_nx;
            cur_n <= n_nx;
            out_p <= p_nx;
        end
    end

    // half-cycle delayed copy stretches the high phase for odd ratios
    always_ff @(negedge clk) begin
        if (rst) begin
            out_n <= 1'b0;
        end else begin
            out_n <= out_p;
        end
    end

    always_comb begin
        byp = (cur_n == div_t'(1));
        odd = cur_n[0] && !byp;
        if (byp) begin
            mclk = clk && run;
        end else if (odd) begin
            mclk = out_p || out_n;
        end else begin
            mclk = out_p;
        end
    end

endmodule

// File: rtl/acg_frame_gen.sv
module acg_frame_gen
    import acg_pkg::*;
#(
    parameter int MCLK_FS  = 512,
    parameter int RATIO_LO = 32,
    parameter int RATIO_HI = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  bratio_e    sel_in,
    output frame_out_t fo
);

    localparam int FC_W   = $clog2(MCLK_FS);
    localparam int BIT_LO = $clog2(MCLK_FS / RATIO_LO) - 1;
    localparam int BIT_HI = $clog2(MCLK_FS / RATIO_HI) - 1;

    logic [FC_W-1:0] fcnt;
    logic [FC_W-1:0] fcnt_nx;
    logic            wrap;
    bratio_e         sel_q;
    bratio_e         sel_nx;
    frame_out_t      fo_nx;

    always_comb begin
        fcnt_nx     = fcnt + FC_W'(1);
        wrap        = (fcnt_nx == '0);
        sel_nx      = wrap ? sel_in : sel_q;
        fo_nx.bclk  = (sel_nx == BR_HIGH) ? fcnt_nx[BIT_HI] : fcnt_nx[BIT_LO];
        fo_nx.lrclk = fcnt_nx[FC_W-1];
        fo_nx.stb   = wrap;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fcnt  <= '0;
            sel_q <= sel_in;
            fo    <= '0;
        end else if (tick) begin
            fcnt  <= fcnt_nx;
            sel_q <= sel_nx;
            fo    <= fo_nx;
        end else begin
            fo.stb <= 1'b0;
        end
    end

endmodule

// File: rtl/acg_clkgen.sv
module acg_clkgen
    import acg_pkg::*;
#(
    parameter int MCLK_FS  = 512,
    parameter int RATIO_LO = 32,
    parameter int RATIO_HI = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ACG_DIV_W-1:0] div_val,
    input  logic                 bclk_sel,
    output logic                 mclk,
    output logic                 bclk,
    output logic                 lrclk,
    output logic                 frame_stb
);

    logic       tick;
    frame_out_t fo;

    acg_mclk_div div_i (
        .clk       (clk),
        .rst       (rst),
        .div_in    (div_t'(div_val)),
        .mclk      (mclk),
        .fall_tick (tick)
    );

    acg_frame_gen #(
        .MCLK_FS  (MCLK_FS),
        .RATIO_LO (RATIO_LO),
        .RATIO_HI (RATIO_HI)
    ) frm_i (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .sel_in (bratio_e'(bclk_sel)),
        .fo     (fo)
    );

    assign bclk      = fo.bclk;
    assign lrclk     = fo.lrclk;
    assign frame_stb = fo.stb;

endmodule

// File: rtl/acg_clkgen_chk.sv
module acg_clkgen_chk (
    input logic clk,
    input logic rst,
    input logic mclk,
    input logic bclk,
    input logic lrclk,
    input logic frame_stb
);

    p_reset_low_r11: assert property (@(posedge clk)
        rst |=> (!mclk && !bclk && !lrclk && !frame_stb));

    p_stb_single_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && frame_stb) |=> !frame_stb);

    p_stb_lr_fall_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && frame_stb) |-> (!lrclk && $past(lrclk)));

    p_lr_on_bclk_fall_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(lrclk)) |-> $fell(bclk));

endmodule

bind acg_clkgen acg_clkgen_chk chk_i (.*);

// File: tb/acg_clkgen_tb_top.sv
module acg_clkgen_tb_top;

    logic       clk;
    logic       rst;
    logic [7:0] div_val;
    logic       bclk_sel;
    logic       mclk;
    logic       bclk;
    logic       lrclk;
    logic       frame_stb;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    acg_clkgen dut_i (
        .clk       (clk),
        .rst       (rst),
        .div_val   (div_val),
        .bclk_sel  (bclk_sel),
        .mclk      (mclk),
        .bclk      (bclk),
        .lrclk     (lrclk),
        .frame_stb (frame_stb)
    );

    initial begin
        clk = 1'b0;
        forever #4 clk = ~clk;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // sample 2 ns after a rising edge
    task automatic step();
        @(posedge clk);
        #2;
    endtask

    // high and low spans of mclk in half fast cycles
    task automatic mclk_runs(output int hi, output int lo);
        step();
        while (mclk) #4;
        while (!mclk) #4;
        hi = 0;
        while (mclk) begin hi++; #4; end
        lo = 0;
        while (!mclk) begin lo++; #4; end
    endtask

    // high and low spans of bclk in fast cycles
    task automatic bclk_runs(output int hi, output int lo);
        step();
        while (bclk) step();
        while (!bclk) step();
        hi = 0;
        while (bclk) begin hi++; step(); end
        lo = 0;
        while (!bclk) begin lo++; step(); end
    endtask

    task automatic wait_stb();
        step();
        while (!frame_stb) step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual %0d cycles expected fewer", 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int h;
        int l;
        int e;
        rst      = 1'b1;
        div_val  = 8'd4;
        bclk_sel = 1'b0;
        repeat (3) step();
        // R11: reset state
        chk(!mclk && !bclk && !lrclk && !frame_stb, "R11 outputs low in reset",
            {mclk, bclk, lrclk, frame_stb}, 0);
        rst = 1'b0;

        // R1 R2 R3: sweep of divide values
        for (int d = 0; d < 10; d++) begin
            div_val = 8'(d);
            repeat (40) step();
            mclk_runs(h, l);
            e = (d == 0) ? 1 : d;
            chk(h + l == 2 * e, $sformatf("R1 mclk period halves div=%0d", d), h + l, 2 * e);
            chk(h == e && l == e, $sformatf("R2 mclk high halves div=%0d", d), h, e);
            if (d == 5) chk(h == 5 && l == 5, "R3 div 5 gives 2.5 cycles high of 5", h, 5);
        end

        // R4: change mid-period, even and odd
        for (int t = 0; t < 3; t++) begin
            int o_n;
            int n_n;
            bit seen_new;
            o_n = (t == 0) ? 4 : (t == 1) ? 3 : 7;
            n_n = (t == 0) ? 6 : (t == 1) ? 5 : 2;
            div_val = 8'(o_n);
            repeat (30) step();
            seen_new = 0;
            fork
                begin #37; div_val = 8'(n_n); end
                begin
                    for (int k = 0; k < 6; k++) begin
                        mclk_runs(h, l);
                        if (h == n_n && l == n_n) seen_new = 1;
                        chk((h == l) && ((h == n_n) || (h == o_n && !seen_new)),
                            $sformatf("R4 period %0d->%0d whole", o_n, n_n), h * 100 + l,
                            seen_new ? n_n * 101 : o_n * 101);
                    end
                end
            join
            chk(seen_new, "R4 new value applied", h, n_n);
        end

        // R5: bit clock ratios at N=2
        div_val  = 8'd2;
        bclk_sel = 1'b0;
        wait_stb();
        bclk_runs(h, l);
        chk(h == 16 && l == 16, "R5 bclk 32x high/low cycles", h * 100 + l, 1616);
        bclk_sel = 1'b1;
        wait_stb();
        bclk_runs(h, l);
        chk(h == 8 && l == 8, "R5 bclk 64x high/low cycles", h * 100 + l, 808);

        // R6 R9: frame clock and strobe at N=1
        div_val  = 8'd1;
        bclk_sel = 1'b0;
        repeat (2) wait_stb();
        chk(!lrclk, "R9 lrclk low at strobe", lrclk, 0);
        step();
        chk(!frame_stb, "R9 strobe one cycle", frame_stb, 0);
        h = 1;
        while (!lrclk) begin h++; step(); end
        chk(h == 256, "R6 lrclk low cycles", h, 256);
        l = 0;
        while (lrclk) begin l++; step(); if (frame_stb) break; end
        chk(l == 256, "R6 lrclk high cycles", l, 256);
        chk(frame_stb, "R9 next strobe 512 cycles after", h + l, 512);

        // R7 R8: phase relation at N=4
        div_val = 8'd4;
        repeat (2) wait_stb();
        begin
            bit pm;
            bit pb;
            bit pl;
            int bchg;
            int lchg;
            bchg = 0;
            lchg = 0;
            pm = mclk; pb = bclk; pl = lrclk;
            for (int c = 0; c < 2100; c++) begin
                step();
                if (bclk != pb) begin
                    bchg++;
                    chk(pm && !mclk, "R7 bclk moves with mclk fall", {pm, mclk}, 2);
                end
                if (lrclk != pl) begin
                    lchg++;
                    chk(pb && !bclk, "R8 lrclk moves on bclk fall", {pb, bclk}, 2);
                end
                pm = mclk; pb = bclk; pl = lrclk;
            end
            chk(bchg >= 60, "R7 bclk edges seen", bchg, 60);
            chk(lchg >= 2, "R8 lrclk edges seen", lchg, 2);
        end

        // R10: ratio change mid-frame at N=1
        div_val  = 8'd1;
        bclk_sel = 1'b0;
        repeat (2) wait_stb();
        repeat (100) step();
        bclk_sel = 1'b1;
        bclk_runs(h, l);
        chk(h == 8, "R10 old ratio kept in frame", h, 8);
        wait_stb();
        bclk_runs(h, l);
        chk(h == 4 && l == 4, "R10 new ratio after frame start", h * 100 + l, 404);

        // R11: reset in mid-run
        repeat (37) step();
        rst = 1'b1;
        step();
        chk(!mclk && !bclk && !lrclk && !frame_stb, "R11 outputs low after reset edge",
            {mclk, bclk, lrclk, frame_stb}, 0);
        #4;
        chk(!mclk, "R11 mclk low mid-cycle in reset", mclk, 0);
        step();
        rst = 1'b0;
        div_val = 8'd3;
        repeat (10) step();
        mclk_runs(h, l);
        chk(h == 3 && l == 3, "R1 running again after reset", h * 100 + l, 303);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule